// File: doc/BRIEF.md
# Pattern Bit Error Rate Tester

This block sends a known test pattern on a serial line and checks the same kind of pattern coming back. Each direction has its own clock enable. The transmit side produces one of three sources: a 2^15-1 pseudo-random sequence, a 2^20-1 quasi-random sequence with its zero runs limited, or a repeating word of 1 to 32 bits set by the user. It can invert single bits on request, or invert bits at a fixed rate of one per 10^n bits.

The receive side needs no seed or phase from outside. While it hunts, it builds its prediction from the bits it receives. It declares lock after a run of matching bits, and from then on it predicts from its own state. After lock it counts received bits and mismatched bits. When errors become dense it drops lock and hunts again. A snapshot pulse copies both running counts into the output registers and restarts the counts.

Top module: `pattern_bert`

## Requirements
- R1: After reset, `tx_bit`, `rx_sync`, `bits_seen` and `errs_seen` are all zero.
- R2: With `mode` = 0, the transmit stream follows b[n] = b[n-15] xor b[n-14]. The generator history is all ones after reset. `tx_bit` takes a new bit only on a clock with `tx_en` high and holds otherwise.
- R3: With `mode` = 1, the underlying sequence follows u[n] = u[n-20] xor u[n-17] from an all-ones history. A bit that would follow 14 consecutive transmitted zeros is sent as one, so no transmitted zero run exceeds 14. The underlying sequence is not altered by this.
- R4: With `mode` = 2 or 3, `pat` is sent LSB first, bits 0 through `pat_last`, and then repeats. The pattern length is `pat_last` + 1, from 1 to 32.
- R5: A pulse on `inj_one` inverts exactly one transmitted bit. This is the bit generated in the same cycle if `tx_en` is high, or else the next generated bit.
- R6: `inj_rate` = n (1 to 7) inverts every 10^n-th generated bit. The count starts when `inj_rate` leaves 0, and 0 disables rate insertion. If a single request lands on a rate-inverted bit, that bit is inverted once and the request is consumed.
- R7: The checker seeds itself from received data. `rx_sync` rises after the 32nd consecutive matching bit sampled with `rx_en`, and never sooner.
- R8: In lock, received bits are grouped in 64-bit blocks that start at lock. The 6th mismatch within one block clears `rx_sync` after that bit, while 5 mismatches in a block keep lock. Hunting then restarts from the incoming data.
- R9: Only bits sampled with `rx_en` while `rx_sync` is high are counted, and the mismatched ones among them are also counted as errors.
- R10: A `snap` pulse loads `bits_seen`/`errs_seen` with the running counts. It restarts the running counts, and a bit counted in the same cycle goes into the new counts. The snapshot outputs change only on `snap`.
- R11: Running counters stop at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 PRBS15, 1 QRSS, 2/3 user pattern |
| pat | input | 32 | User pattern word, LSB sent first |
| pat_last | input | 5 | Index of last pattern bit (length - 1) |
| tx_en | input | 1 | Transmit bit enable |
| inj_one | input | 1 | Single error request pulse |
| inj_rate | input | 3 | Rate insertion exponent, 0 off |
| tx_bit | output | 1 | Transmitted bit |
| rx_en | input | 1 | Receive bit enable |
| rx_bit | input | 1 | Received bit |
| rx_sync | output | 1 | Checker locked |
| snap | input | 1 | Snapshot and restart pulse |
| bits_seen | output | CNT_W | Snapshot of counted bits |
| errs_seen | output | CNT_W | Snapshot of errored bits |

## Verification
Two transmit events can fall in the same cycle: a single-error request and a bit that the rate counter marks for inversion. The bench runs the rate counter at one per ten and pulses the request on exactly the tenth bit. It expects that bit to be inverted once and the following bit to arrive clean. On the receive side, the bench also issues a snapshot pulse together with an errored received bit. It expects the first snapshot to leave that bit out, and the next snapshot to hold it as one bit and one error.

// File: rtl/pattern_bert.sv
`timescale 1ns/1ps
module pattern_bert #(
  parameter int CNT_W          = 32,
  parameter int HIST_W         = 32,
  parameter int SYNC_RUN       = 32,
  parameter int WIN            = 64,
  parameter int LOSS_ERRS      = 6,
  parameter int QRSS_MAX_ZEROS = 14,
  parameter int MAX_EXP        = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode,
  input  logic [HIST_W-1:0]         pat,
  input  logic [$clog2(HIST_W)-1:0] pat_last,
  input  logic                      tx_en,
  input  logic                      inj_one,
  input  logic [2:0]                inj_rate,
  output logic                      tx_bit,
  input  logic                      rx_en,
  input  logic                      rx_bit,
  output logic                      rx_sync,
  input  logic                      snap,
  output logic [CNT_W-1:0]          bits_seen,
  output logic [CNT_W-1:0]          errs_seen
);
  localparam int LEN_W = $clog2(HIST_W);
  localparam int GC_W  = $clog2(SYNC_RUN);
  localparam int WC_W  = $clog2(WIN);
  localparam int EC_W  = $clog2(LOSS_ERRS + 1);
  localparam int ZR_W  = $clog2(QRSS_MAX_ZEROS + 1);
  localparam int RC_W  = $clog2(10 ** MAX_EXP);
  localparam logic [1:0] M_P15  = 2'd0;
  localparam logic [1:0] M_QRSS = 2'd1;

  function automatic logic next_bit(input logic [1:0] m, input logic [HIST_W-1:0] h);
    if (m == M_P15) return (h[14] ^ h[13]) | ~(|h[14:0]);
    return (h[19] ^ h[16]) | ~(|h[19:0]);
  endfunction

  function automatic logic [RC_W-1:0] rate_top(input logic [2:0] n);
    logic [RC_W-1:0] p;
    p = RC_W'(1);
    for (int i = 0; i < MAX_EXP; i++)
      if (i < 32'(n)) p = p * RC_W'(10);
    return p - RC_W'(1);
  endfunction

  wire is_pat = mode[1];

  // transmit generator
  logic [HIST_W-1:0] g;
  logic [ZR_W-1:0]   gz;
  logic [LEN_W-1:0]  ph;
  logic              pend;
  logic [RC_W-1:0]   rc;

  wire g_nb     = next_bit(mode, g);
  wire g_force  = (mode == M_QRSS) && (gz == ZR_W'(QRSS_MAX_ZEROS));
  wire g_out    = is_pat ? pat[ph] : (g_nb | g_force);
  wire rate_on  = inj_rate != 3'd0;
  wire rate_hit = rate_on && (rc == rate_top(inj_rate));
  wire flip     = pend | inj_one | rate_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g      <= '1;
      gz     <= '0;
      ph     <= '0;
      pend   <= 1'b0;
      rc     <= '0;
      tx_bit <= 1'b0;
    end else begin
      if (!rate_on) rc <= '0;
      if (tx_en) begin
        tx_bit <= g_out ^ flip;
        g      <= {g[HIST_W-2:0], g_nb};
        gz     <= g_out ? '0 : (gz == ZR_W'(QRSS_MAX_ZEROS) ? gz : gz + 1'b1);
        ph     <= (ph >= pat_last) ? '0 : ph + 1'b1;
        pend   <= 1'b0;
        if (rate_on) rc <= rate_hit ? '0 : rc + 1'b1;
      end else if (inj_one) begin
        pend <= 1'b1;
      end
    end
  end

  // receive checker
  logic [HIST_W-1:0] c;
  logic [ZR_W-1:0]   cz;
  logic [GC_W-1:0]   gc;
  logic [WC_W-1:0]   wc;
  logic [EC_W-1:0]   ec;
  logic [CNT_W-1:0]  bcnt, ecnt;

  wire c_nb    = next_bit(mode, c);
  wire c_force = (mode == M_QRSS) && (cz == ZR_W'(QRSS_MAX_ZEROS));
  wire c_exp   = is_pat ? c[pat_last] : (c_nb | c_force);
  wire miss    = rx_bit ^ c_exp;
  wire c_in    = is_pat ? (rx_sync ? c_exp : rx_bit)
                        : ((rx_sync || c_force) ? c_nb : rx_bit);
  wire z_src   = rx_sync ? c_exp : rx_bit;
  wire [EC_W-1:0] ec_nxt = ec + EC_W'(miss);
  wire drop    = rx_sync && miss && (ec_nxt >= EC_W'(LOSS_ERRS));
  wire inc_b   = rx_en && rx_sync;
  wire inc_e   = inc_b && miss;
  wire win_end = wc == WC_W'(WIN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c       <= '0;
      cz      <= '0;
      gc      <= '0;
      wc      <= '0;
      ec      <= '0;
      rx_sync <= 1'b0;
    end else if (rx_en) begin
      c  <= {c[HIST_W-2:0], c_in};
      cz <= z_src ? '0 : (cz == ZR_W'(QRSS_MAX_ZEROS) ? cz : cz + 1'b1);
      if (!rx_sync) begin
        if (miss) gc <= '0;
        else if (gc == GC_W'(SYNC_RUN - 1)) begin
          rx_sync <= 1'b1;
          gc      <= '0;
          wc      <= '0;
          ec      <= '0;
        end else gc <= gc + 1'b1;
      end else if (drop) begin
        rx_sync <= 1'b0;
        gc      <= '0;
      end else begin
        wc <= win_end ? '0 : wc + 1'b1;
        ec <= win_end ? '0 : ec_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt      <= '0;
      ecnt      <= '0;
      bits_seen <= '0;
      errs_seen <= '0;
    end else if (snap) begin
      bits_seen <= bcnt;
      errs_seen <= ecnt;
      bcnt      <= CNT_W'(inc_b);
      ecnt      <= CNT_W'(inc_e);
    end else begin
      if (inc_b && bcnt != '1) bcnt <= bcnt + 1'b1;
      if (inc_e && ecnt != '1) ecnt <= ecnt + 1'b1;
    end
  end
endmodule

module pattern_bert_chk #(parameter int CNT_W = 32) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_bit,
  input logic             rx_en,
  input logic             rx_sync,
  input logic             snap,
  input logic [CNT_W-1:0] bits_seen,
  input logic [CNT_W-1:0] errs_seen,
  input logic [CNT_W-1:0] bcnt,
  input logic [CNT_W-1:0] ecnt
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> $stable(tx_bit)); // R2
  AST_SYNC_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_sync) |-> $past(rx_en)); // R7
  AST_LOSS_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(rx_sync) |-> $past(rx_en)); // R8
  AST_HUNT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (!rx_sync && !snap) |=> $stable(bcnt) && $stable(ecnt)); // R9
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (!rx_en && !snap) |=> $stable(bcnt) && $stable(ecnt) && $stable(rx_sync)); // R9
  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ecnt <= bcnt); // R9
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !snap |=> $stable(bits_seen) && $stable(errs_seen)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (bcnt == {CNT_W{1'b1}} && !snap) |=> bcnt == {CNT_W{1'b1}}); // R11
endmodule

bind pattern_bert pattern_bert_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit), .rx_en(rx_en),
  .rx_sync(rx_sync), .snap(snap), .bits_seen(bits_seen), .errs_seen(errs_seen),
  .bcnt(bcnt), .ecnt(ecnt)
);

// File: tb/sim_pattern_bert.sv
`timescale 1ns/1ps
module sim_pattern_bert;
  localparam int CW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [31:0] pat = '0;
  logic [4:0] pat_last = '0;
  logic tx_en = 1'b0, inj_one = 1'b0;
  logic [2:0] inj_rate = '0;
  logic tx_bit;
  logic rx_en = 1'b0, rx_bit = 1'b0, snap = 1'b0;
  logic rx_sync;
  logic [CW-1:0] bits_seen, errs_seen;
  int n_chk = 0, n_bad = 0;
  logic [31:0] mh;
  int mz, mp, pos, run, maxrun, nerr;
  int unsigned seed_v;
  bit b;

  always #5 clk = ~clk;

  pattern_bert #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pat(pat), .pat_last(pat_last),
    .tx_en(tx_en), .inj_one(inj_one), .inj_rate(inj_rate), .tx_bit(tx_bit),
    .rx_en(rx_en), .rx_bit(rx_bit), .rx_sync(rx_sync), .snap(snap),
    .bits_seen(bits_seen), .errs_seen(errs_seen)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    mode = m; rst_n = 1'b0; tx_en = 0; inj_one = 0; rx_en = 0; snap = 0; inj_rate = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mh = '1; mz = 0; mp = 0; pos = 0;
  endtask

  task automatic model_next(output bit o);
    bit nb;
    nb = (mode == 2'd0) ? (mh[14] ^ mh[13]) : (mh[19] ^ mh[16]);
    if (mode[1]) begin
      o = pat[mp];
      mp = (mp >= int'(pat_last)) ? 0 : mp + 1;
    end else o = (mode == 2'd1 && mz == 14) ? 1'b1 : nb;
    mh = {mh[30:0], nb};
    mz = o ? 0 : (mz == 14 ? 14 : mz + 1);
  endtask

  task automatic tx_step(input bit en, input bit one, input bit fl, input string req);
    bit e; logic prev;
    prev = tx_bit;
    tx_en = en; inj_one = one;
    @(negedge clk);
    tx_en = 0; inj_one = 0;
    if (en) begin
      model_next(e);
      chk(tx_bit === (e ^ fl), req, tx_bit, e ^ fl);
    end else chk(tx_bit === prev, req, tx_bit, prev);
  endtask

  task automatic rx_step(input bit v, input bit sn);
    bit s0;
    s0 = rx_sync;
    rx_en = 1; rx_bit = v; snap = sn;
    @(negedge clk);
    rx_en = 0; snap = 0;
    if (s0 && rx_sync) pos++;
    else if (!s0 && rx_sync) pos = 0;
  endtask

  task automatic snap_only();
    snap = 1;
    @(negedge clk);
    snap = 0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_v = $urandom(7);
    // R1
    do_reset(2'd0);
    chk(tx_bit === 1'b0, "R1 tx_bit", tx_bit, 0);
    chk(rx_sync === 1'b0, "R1 rx_sync", rx_sync, 0);
    chk(bits_seen === '0, "R1 bits_seen", bits_seen, 0);
    chk(errs_seen === '0, "R1 errs_seen", errs_seen, 0);

    // R2 PRBS15 with random gaps
    for (int i = 0; i < 300; i++) tx_step(1'($urandom_range(0, 1)), 0, 0, "R2");

    // R3 QRSS with zero-run limit
    do_reset(2'd1);
    run = 0; maxrun = 0;
    for (int i = 0; i < 60000; i++) begin
      tx_step(1, 0, 0, "R3");
      run = tx_bit ? 0 : run + 1;
      if (run > maxrun) maxrun = run;
    end
    chk(maxrun <= 14, "R3 zero run", maxrun, 14);

    // R4 user patterns of several lengths
    pat = $urandom(); pat_last = 5'd6;
    do_reset(2'd2);
    for (int i = 0; i < 50; i++) tx_step(1'($urandom_range(0, 1)), 0, 0, "R4");
    pat = $urandom(); pat_last = 5'd31;
    do_reset(2'd3);
    for (int i = 0; i < 70; i++) tx_step(1, 0, 0, "R4");
    pat = 32'h1; pat_last = 5'd0;
    do_reset(2'd2);
    for (int i = 0; i < 10; i++) tx_step(1, 0, 0, "R4");

    // R5 single-shot insertion
    do_reset(2'd0);
    for (int i = 0; i < 5; i++) tx_step(1, 0, 0, "R5");
    tx_step(0, 1, 0, "R5");
    tx_step(1, 0, 1, "R5");
    tx_step(1, 0, 0, "R5");
    tx_step(1, 1, 1, "R5");
    tx_step(1, 0, 0, "R5");
    tx_step(0, 0, 0, "R5");

    // R6 constant-rate insertion and coincidence with a single request
    do_reset(2'd0);
    inj_rate = 3'd1;
    for (int k = 0; k < 100; k++) tx_step(1, 0, (k % 10) == 9, "R6");
    for (int k = 100; k < 130; k++) tx_step(1, k == 109, (k % 10) == 9, "R6 coincide");
    inj_rate = 3'd0;
    tx_step(0, 0, 0, "R6");
    inj_rate = 3'd2;
    for (int k = 0; k < 250; ) begin
      if ($urandom_range(0, 3) == 0) tx_step(0, 0, 0, "R6");
      else begin tx_step(1, 0, (k % 100) == 99, "R6"); k++; end
    end
    inj_rate = 3'd0;

    // R7 exact lock point on an all-zero 4-bit pattern
    pat = '0; pat_last = 5'd3;
    do_reset(2'd2);
    for (int i = 0; i < 31; i++) rx_step(0, 0);
    chk(rx_sync === 1'b0, "R7 before 32", rx_sync, 0);
    rx_step(0, 0);
    chk(rx_sync === 1'b1, "R7 at 32", rx_sync, 1);

    // R9 R10 counting and snapshot
    snap_only();
    chk(bits_seen == 0, "R10 bits", bits_seen, 0);
    chk(errs_seen == 0, "R10 errs", errs_seen, 0);
    for (int i = 0; i < 100; i++) rx_step(i == 3 || i == 10 || i == 20 || i == 70 || i == 80, 0);
    snap_only();
    chk(bits_seen == 100, "R9 bits", bits_seen, 100);
    chk(errs_seen == 5, "R9 errs", errs_seen, 5);
    for (int i = 0; i < 4; i++) rx_step(0, 0);
    rx_step(1, 1);
    chk(bits_seen == 4, "R10 same-cycle bits", bits_seen, 4);
    chk(errs_seen == 0, "R10 same-cycle errs", errs_seen, 0);
    for (int i = 0; i < 9; i++) rx_step(0, 0);
    snap_only();
    chk(bits_seen == 10, "R10 carried bits", bits_seen, 10);
    chk(errs_seen == 1, "R10 carried errs", errs_seen, 1);

    // R8 loss of lock
    while (pos % 64 != 0) rx_step(0, 0);
    for (int i = 0; i < 5; i++) rx_step(1, 0);
    for (int i = 0; i < 59; i++) rx_step(0, 0);
    chk(rx_sync === 1'b1, "R8 five errors keep lock", rx_sync, 1);
    for (int i = 0; i < 6; i++) begin
      rx_step(1, 0);
      if (i == 4) chk(rx_sync === 1'b1, "R8 fifth", rx_sync, 1);
      if (i == 5) chk(rx_sync === 1'b0, "R8 sixth", rx_sync, 0);
    end
    for (int i = 0; i < 31; i++) rx_step(0, 0);
    chk(rx_sync === 1'b0, "R8 rehunt", rx_sync, 0);
    rx_step(0, 0);
    chk(rx_sync === 1'b1, "R8 relock", rx_sync, 1);

    // R7 R9 PRBS15 receive
    do_reset(2'd0);
    for (int i = 0; i < 31; i++) begin model_next(b); rx_step(b, 0); end
    chk(rx_sync === 1'b0, "R7 prbs early", rx_sync, 0);
    for (int i = 0; i < 16; i++) begin model_next(b); rx_step(b, 0); end
    chk(rx_sync === 1'b1, "R7 prbs lock", rx_sync, 1);
    snap_only();
    for (int i = 0; i < 200; i++) begin model_next(b); rx_step(b ^ (i == 30 || i == 130), 0); end
    snap_only();
    chk(bits_seen == 200, "R9 prbs bits", bits_seen, 200);
    chk(errs_seen == 2, "R9 prbs errs", errs_seen, 2);

    // R3 R7 QRSS receive
    do_reset(2'd1);
    for (int i = 0; i < 31; i++) begin model_next(b); rx_step(b, 0); end
    chk(rx_sync === 1'b0, "R7 qrss early", rx_sync, 0);
    for (int i = 0; i < 89; i++) begin model_next(b); rx_step(b, 0); end
    chk(rx_sync === 1'b1, "R7 qrss lock", rx_sync, 1);
    snap_only();
    for (int i = 0; i < 800; i++) begin model_next(b); rx_step(b, 0); end
    snap_only();
    chk(bits_seen == 800, "R3 qrss bits", bits_seen, 800);
    chk(errs_seen == 0, "R3 qrss errs", errs_seen, 0);

    // R11 saturation
    pat = '0; pat_last = 5'd0;
    do_reset(2'd2);
    for (int i = 0; i < 32; i++) rx_step(0, 0);
    snap_only();
    nerr = 0;
    for (int i = 0; i < 1100; i++) begin
      rx_step((i % 64) == 10, 0);
      if ((i % 64) == 10) nerr++;
    end
    snap_only();
    chk(bits_seen == 1023, "R11 bits saturate", bits_seen, 1023);
    chk(errs_seen == nerr, "R11 errs", errs_seen, nerr);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule